// File: doc/BRIEF.md
# Parallel Sobel Edge Magnitude Array

This block turns three stacked rows of 8-bit pixels into a row of edge-strength pixels. Each row carries LANES+2 pixels. Lane k looks at the 3x3 window made of columns k, k+1 and k+2 of the three rows. Every lane forms the horizontal and vertical Sobel gradients from the eight pixels around the window centre. It adds their absolute values and clamps the sum to the largest pixel value, giving one 8-bit edge pixel per lane.

All lanes share one clocked output stage. A frame of rows presented with the input strobe high gives a full row of results and a valid flag one clock later. A row-buffering front end feeds the block. It shifts a new bottom row in and the two older rows up, and the block produces one output row per strobe.

Top module: `sobel_edge_array`

## Requirements
- R1: While reset is held and on the first edges after release with no strobe, `out_valid` is 0 and every bit of `edge_pix` is 0.
- R2: Pixel column j of each row bus sits in bits [8j+7:8j]. `row_top` is the upper raster row and `row_bot` the lower one. Lane k uses columns k, k+1, k+2 and drives bits [8k+7:8k] of `edge_pix`.
- R3: Naming window pixels P0..P8 in raster order, the horizontal gradient is Gx = (P2 + 2*P5 + P8) - (P0 + 2*P3 + P6), formed as a signed 11-bit value.
- R4: The vertical gradient is Gy = (P6 + 2*P7 + P8) - (P0 + 2*P1 + P2), formed as a signed 11-bit value.
- R5: Each lane outputs |Gx| + |Gy| when that sum is at most 255, and 255 otherwise.
- R6: The window centre P4 has no effect on the lane's own output.
- R7: `out_valid` equals `in_valid` delayed by one clock. The results for a strobed frame appear on `edge_pix` in the same cycle that `out_valid` is 1.
- R8: A clock with `in_valid` low leaves `edge_pix` unchanged, whatever the row inputs carry.
- R9: A uniform window gives 0. A window with a full 0-to-255 step across it, horizontally or vertically, gives exactly 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Rows on the buses are a frame to process |
| row_top | input | 272 | Upper pixel row, 34 pixels of 8 bits |
| row_mid | input | 272 | Middle pixel row |
| row_bot | input | 272 | Lower pixel row |
| out_valid | output | 1 | `edge_pix` holds a new result row |
| edge_pix | output | 256 | 32 clamped edge pixels of 8 bits |

## Verification
The only state is the output register and the valid flag. A fault in either shows at the ports in the clock right after the frame that exposes it. A wrong gradient weight, a swapped tap or a lost sign appears on the affected lane in that same clock. A weak clamp appears only on steep edges, so directed step frames are mixed with random frames. A broken hold shows as a changed `edge_pix` after a clock without the strobe.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

   // Defaults shared by the array and its lanes
   localparam int unsigned DEF_LANES = 32;
   localparam int unsigned DEF_PIX_W = 8;

   // Signed gradient width: a weight-4 sum of pixels needs PIX_W+2 bits,
   // the sign adds one more.
   function automatic int unsigned grad_width(input int unsigned pix_w);
      return pix_w + 3;
   endfunction

   // Saturation variants for the magnitude stage
   typedef enum logic [0:0] {
      SAT_UPPER_BITS = 1'b0,   // any bit above the pixel field forces full scale
      SAT_COMPARE    = 1'b1    // explicit magnitude compare against full scale
   } sat_style_e;

endpackage

// File: rtl/sobel_gradient.sv
module sobel_gradient
   import sobel_pkg::*;
#(
   parameter int unsigned PIX_W = DEF_PIX_W,
   localparam int unsigned GW   = grad_width(PIX_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PIX_W-1:0]     p0,
   input  logic [PIX_W-1:0]     p1,
   input  logic [PIX_W-1:0]     p2,
   input  logic [PIX_W-1:0]     p3,
   input  logic [PIX_W-1:0]     p5,
   input  logic [PIX_W-1:0]     p6,
   input  logic [PIX_W-1:0]     p7,
   input  logic [PIX_W-1:0]     p8,
   output logic signed [GW-1:0] gx,
   output logic signed [GW-1:0] gy
);

   localparam int unsigned FULL = (1 << PIX_W) - 1;

   if (PIX_W < 2) begin : g_bad_width
      $error("sobel_gradient: PIX_W must be at least 2");
   end

   logic [GW-1:0] right_sum, left_sum, low_sum, high_sum;

   // Weight-2 taps built by shifting the zero-extended pixel
   always_comb begin
      right_sum = GW'(p2) + (GW'(p5) << 1) + GW'(p8);
      left_sum  = GW'(p0) + (GW'(p3) << 1) + GW'(p6);
      low_sum   = GW'(p6) + (GW'(p7) << 1) + GW'(p8);
      high_sum  = GW'(p0) + (GW'(p1) << 1) + GW'(p2);
      gx        = $signed(right_sum - left_sum);
      gy        = $signed(low_sum - high_sum);
   end

   // R3
   gx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(gx) <= $signed(GW'(4 * FULL))) && ($signed(gx) >= -$signed(GW'(4 * FULL))));

   // R4
   gy_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(gy) <= $signed(GW'(4 * FULL))) && ($signed(gy) >= -$signed(GW'(4 * FULL))));

   // R9
   flat_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p0 == p1 && p1 == p2 && p2 == p3 && p3 == p5 && p5 == p6 && p6 == p7 && p7 == p8)
      |-> (gx == '0 && gy == '0));

endmodule

// File: rtl/sobel_abs_sat.sv
module sobel_abs_sat
   import sobel_pkg::*;
#(
   parameter int unsigned PIX_W     = DEF_PIX_W,
   parameter sat_style_e  SAT_STYLE = SAT_UPPER_BITS,
   localparam int unsigned GW       = grad_width(PIX_W)
) (
   input  logic signed [GW-1:0] gx,
   input  logic signed [GW-1:0] gy,
   output logic [GW-1:0]        mag_sum,
   output logic [PIX_W-1:0]     pix
);

   logic [GW-1:0] abs_x, abs_y;

   always_comb begin
      abs_x   = gx[GW-1] ? GW'(-gx) : GW'(gx);
      abs_y   = gy[GW-1] ? GW'(-gy) : GW'(gy);
      mag_sum = abs_x + abs_y;
   end

   if (SAT_STYLE == SAT_UPPER_BITS) begin : g_sat_bits
      always_comb pix = (|mag_sum[GW-1:PIX_W]) ? {PIX_W{1'b1}} : mag_sum[PIX_W-1:0];
   end else begin : g_sat_cmp
      localparam logic [GW-1:0] FULL_SCALE = GW'((1 << PIX_W) - 1);
      always_comb pix = (mag_sum > FULL_SCALE) ? {PIX_W{1'b1}} : mag_sum[PIX_W-1:0];
   end

endmodule

// File: rtl/sobel_lane.sv
module sobel_lane
   import sobel_pkg::*;
#(
   parameter int unsigned PIX_W     = DEF_PIX_W,
   parameter sat_style_e  SAT_STYLE = SAT_UPPER_BITS,
   localparam int unsigned GW       = grad_width(PIX_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3*PIX_W-1:0] win_top,
   input  logic [3*PIX_W-1:0] win_mid,
   input  logic [3*PIX_W-1:0] win_bot,
   output logic [PIX_W-1:0]   pix
);

   localparam int unsigned FULL = (1 << PIX_W) - 1;

   logic signed [GW-1:0] gx, gy;
   logic [GW-1:0]        mag_sum;

   // Centre pixel win_mid[PIX_W +: PIX_W] is deliberately not routed
   sobel_gradient #(.PIX_W(PIX_W)) u_grad (
      .clk   (clk),
      .rst_n (rst_n),
      .p0    (win_top[0*PIX_W +: PIX_W]),
      .p1    (win_top[1*PIX_W +: PIX_W]),
      .p2    (win_top[2*PIX_W +: PIX_W]),
      .p3    (win_mid[0*PIX_W +: PIX_W]),
      .p5    (win_mid[2*PIX_W +: PIX_W]),
      .p6    (win_bot[0*PIX_W +: PIX_W]),
      .p7    (win_bot[1*PIX_W +: PIX_W]),
      .p8    (win_bot[2*PIX_W +: PIX_W]),
      .gx    (gx),
      .gy    (gy)
   );

   sobel_abs_sat #(.PIX_W(PIX_W), .SAT_STYLE(SAT_STYLE)) u_mag (
      .gx      (gx),
      .gy      (gy),
      .mag_sum (mag_sum),
      .pix     (pix)
   );

   // R5
   clamp_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mag_sum > GW'(FULL)) |-> (pix == PIX_W'(FULL)));

   // R5
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mag_sum <= GW'(FULL)) |-> (GW'(pix) == mag_sum));

endmodule

// File: rtl/sobel_edge_array.sv
module sobel_edge_array
   import sobel_pkg::*;
#(
   parameter int unsigned LANES     = DEF_LANES,
   parameter int unsigned PIX_W     = DEF_PIX_W,
   parameter sat_style_e  SAT_STYLE = SAT_UPPER_BITS,
   localparam int unsigned COLS     = LANES + 2,
   localparam int unsigned ROW_W    = COLS * PIX_W,
   localparam int unsigned OUT_W    = LANES * PIX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [ROW_W-1:0] row_top,
   input  logic [ROW_W-1:0] row_mid,
   input  logic [ROW_W-1:0] row_bot,
   output logic             out_valid,
   output logic [OUT_W-1:0] edge_pix
);

   if (LANES < 1) begin : g_bad_lanes
      $error("sobel_edge_array: LANES must be at least 1");
   end

   logic [OUT_W-1:0] lane_pix;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      sobel_lane #(.PIX_W(PIX_W), .SAT_STYLE(SAT_STYLE)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .win_top (row_top[k*PIX_W +: 3*PIX_W]),
         .win_mid (row_mid[k*PIX_W +: 3*PIX_W]),
         .win_bot (row_bot[k*PIX_W +: 3*PIX_W]),
         .pix     (lane_pix[k*PIX_W +: PIX_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         edge_pix  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) edge_pix <= lane_pix;
      end
   end

   // R7
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R7
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(edge_pix));

   // R7
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (edge_pix == $past(lane_pix)));

endmodule

// File: tb/tb_sobel_edge_array.sv
`timescale 1ns/1ps
module tb_sobel_edge_array;

   localparam int LANES = 32;
   localparam int PW    = 8;
   localparam int ROWB  = (LANES + 2) * PW;
   localparam int OUTB  = LANES * PW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [ROWB-1:0] row_top = '0, row_mid = '0, row_bot = '0;
   logic            out_valid;
   logic [OUTB-1:0] edge_pix;

   int n_checks = 0;
   int n_errors = 0;
   logic [OUTB-1:0] last_out = '0;

   always #2.5 clk = ~clk;

   sobel_edge_array dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .row_top(row_top), .row_mid(row_mid), .row_bot(row_bot),
      .out_valid(out_valid), .edge_pix(edge_pix)
   );

   function automatic logic [OUTB-1:0] model(input logic [ROWB-1:0] t,
                                              input logic [ROWB-1:0] m,
                                              input logic [ROWB-1:0] b);
      logic [OUTB-1:0] r;
      r = '0;
      for (int k = 0; k < LANES; k++) begin
         int a0, a1, a2, a3, a5, a6, a7, a8, gx, gy, mg;
         a0 = int'(t[k*PW +: PW]);     a1 = int'(t[(k+1)*PW +: PW]); a2 = int'(t[(k+2)*PW +: PW]);
         a3 = int'(m[k*PW +: PW]);     a5 = int'(m[(k+2)*PW +: PW]);
         a6 = int'(b[k*PW +: PW]);     a7 = int'(b[(k+1)*PW +: PW]); a8 = int'(b[(k+2)*PW +: PW]);
         gx = (a2 + 2*a5 + a8) - (a0 + 2*a3 + a6);
         gy = (a6 + 2*a7 + a8) - (a0 + 2*a1 + a2);
         mg = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
         if (mg > 255) mg = 255;
         r[k*PW +: PW] = PW'(mg);
      end
      return r;
   endfunction

   function automatic logic [ROWB-1:0] rand_row();
      logic [ROWB-1:0] r;
      for (int i = 0; i < ROWB/32; i++) r[i*32 +: 32] = $urandom;
      for (int i = (ROWB/32)*32; i < ROWB; i++) r[i] = 1'($urandom);
      return r;
   endfunction

   task automatic check(input string tag, input logic [OUTB-1:0] act,
                        input logic [OUTB-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // Drive one frame at the falling edge, check just after the capturing edge
   task automatic frame(input string tag, input logic v, input logic [ROWB-1:0] t,
                        input logic [ROWB-1:0] m, input logic [ROWB-1:0] b);
      logic [OUTB-1:0] exp;
      @(negedge clk);
      in_valid = v; row_top = t; row_mid = m; row_bot = b;
      exp = v ? model(t, m, b) : last_out;
      @(posedge clk);
      #1;
      check_bit({tag, " R7 valid"}, out_valid, v);
      check(tag, edge_pix, exp);
      last_out = exp;
   endtask

   initial begin
      #(200000 * 5);
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      logic [ROWB-1:0] t, m, b;
      void'($urandom(32'h5EED_0B1E));
      repeat (4) @(posedge clk);
      #1;
      // R1: state held in reset
      check_bit("R1 valid in reset", out_valid, 1'b0);
      check("R1 data in reset", edge_pix, '0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check_bit("R1 valid after release", out_valid, 1'b0);
      check("R1 data after release", edge_pix, '0);

      // R9: uniform window
      t = {(LANES+2){8'h5A}};
      frame("R9 uniform", 1'b1, t, t, t);

      // R9 / R3: vertical step between columns 16 and 17
      t = '0;
      for (int c = 17; c < LANES+2; c++) t[c*PW +: PW] = 8'hFF;
      frame("R9 R3 vertical step", 1'b1, t, t, t);

      // R9 / R4: horizontal step, bottom row bright
      frame("R9 R4 horizontal step", 1'b1, '0, '0, {(LANES+2){8'hFF}});

      // R6: single bright pixel in the middle row at column 10
      m = '0; m[10*PW +: PW] = 8'hFF;
      frame("R6 centre pixel", 1'b1, '0, m, '0);
      n_checks++;
      if (edge_pix[9*PW +: PW] !== 8'h00) begin
         n_errors++;
         $display("FAIL R6 own lane: actual=%h expected=00", edge_pix[9*PW +: PW]);
      end

      // R2: ramp in the top row exposes column order
      t = '0;
      for (int c = 0; c < LANES+2; c++) t[c*PW +: PW] = PW'(c * 7);
      frame("R2 column ramp", 1'b1, t, '0, '0);

      // R8: idle clocks with changing data hold the result
      frame("R8 hold 1", 1'b0, rand_row(), rand_row(), rand_row());
      frame("R8 hold 2", 1'b0, rand_row(), rand_row(), rand_row());

      // R5 / R3 / R4: random frames with idle gaps
      for (int i = 0; i < 40; i++) begin
         logic v;
         v = ($urandom % 4) != 0;
         frame(v ? "R5 random" : "R8 random idle", v, rand_row(), rand_row(), rand_row());
      end

      // R5: low-contrast random frames stay below the clamp
      for (int i = 0; i < 8; i++) begin
         t = '0; m = '0; b = '0;
         for (int c = 0; c < LANES+2; c++) begin
            t[c*PW +: PW] = PW'($urandom % 24);
            m[c*PW +: PW] = PW'($urandom % 24);
            b[c*PW +: PW] = PW'($urandom % 24);
         end
         frame("R5 unclamped", 1'b1, t, m, b);
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule